// File: doc/BRIEF.md
# Per-Channel Audio Auto-Mute Detector

This block sits behind the serial audio receiver and in front of the level controller of a stereo output path. It inspects each incoming signed PCM sample and, separately for every channel, counts how many valid samples in an unbroken run were silent. A silent sample has every bit clear (zero) or every bit set (minus one). When a channel's run reaches the configured length, which defaults to 8192 samples, the block raises that channel's mute request. The first valid sample that is not silent drops the request again.

The mute request does not act on the audio itself. A downstream level controller takes it in the same way as a volume change, so it follows the immediate, zero-cross or ramped policy that the controller uses. A combined mute-pin output reports when both channels are muted. An enable input turns the function on and off. A system register normally holds this enable at 1.

Top module: `amute_detector`

## Requirements
- R1: A sample counts as silent exactly when all SAMPLE_W bits are 0 or all are 1. Every other value is non-silent. Channel c reads bits [c*SAMPLE_W +: SAMPLE_W] of `smp_i`.
- R2: `mute_o[c]` goes high on the clock edge that accepts the RUN_LEN-th consecutive valid silent sample of channel c, and never earlier.
- R3: The run count saturates at RUN_LEN. A mute therefore holds through any length of continued silence.
- R4: A valid non-silent sample clears `mute_o[c]` on the edge that accepts it and restarts the run at zero. A further RUN_LEN silent samples are then needed to mute again.
- R5: Each channel's count and mute depend only on that channel's sample and strobe.
- R6: A cycle with `vld_i[c]` low leaves channel c's count and mute unchanged, whatever the sample bus holds.
- R7: `mute_pin_o` is high exactly when every channel's `mute_o` is high, in the same cycle.
- R8: While `en_i` is low, each edge clears every count and drives every mute output and `mute_pin_o` low.
- R9: Synchronous reset clears all counts and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Auto-mute enable |
| vld_i | input | NUM_CH | Per-channel sample strobe |
| smp_i | input | NUM_CH*SAMPLE_W | Packed signed samples, channel 0 in the low bits |
| mute_o | output | NUM_CH | Per-channel mute request to the level controller |
| mute_pin_o | output | 1 | High while all channels are muted |

## Verification
Every result is a register output, so it is due one clock edge after the stimulus that causes it. `mute_o` and `mute_pin_o` are both registered from the same next-state values, so they change on the same edge. The bench applies inputs on the falling edge, lets one rising edge pass, and compares both outputs with its arithmetic model on the next falling edge. The first possible mute is the edge that takes sample RUN_LEN, so the checks around that point are exact to the cycle. A reduced configuration (8-bit samples, a run of 16) makes it possible to sweep all 256 sample values on both channels.

// File: rtl/amute_pkg.sv
package amute_pkg;
  // Width of a saturating counter that must hold the value lim.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/amute_silence_det.sv
module amute_silence_det #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] smp,
  output logic                silent
);
  // A sample is silent when it is exact zero or exact minus one.
  always_comb begin
    silent = (smp == {SAMPLE_W{1'b0}}) || (smp == {SAMPLE_W{1'b1}});
  end
endmodule

// File: rtl/amute_run_ctr.sv
module amute_run_ctr
  import amute_pkg::*;
#(
  parameter int unsigned RUN_LEN = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vld,
  input  logic silent,
  output logic mute_q,
  output logic mute_nxt
);
  localparam int unsigned CNT_W = cnt_width(RUN_LEN);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt  = cnt_q;
    mute_nxt = mute_q;
    if (!en) begin
      cnt_nxt  = '0;
      mute_nxt = 1'b0;
    end else if (vld) begin
      if (silent) begin
        if (cnt_q != LIM) cnt_nxt = cnt_q + 1'b1;
        mute_nxt = (cnt_nxt == LIM);
      end else begin
        cnt_nxt  = '0;
        mute_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mute_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      mute_q <= mute_nxt;
    end
  end
endmodule

// File: rtl/amute_pin.sv
module amute_pin #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] mute_nxt,
  output logic              pin_q
);
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= &mute_nxt;
  end
endmodule

// File: rtl/amute_detector.sv
module amute_detector #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192,
  parameter int unsigned NUM_CH   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en_i,
  input  logic [NUM_CH-1:0]            vld_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]   smp_i,
  output logic [NUM_CH-1:0]            mute_o,
  output logic                         mute_pin_o
);
  logic [NUM_CH-1:0] silent;
  logic [NUM_CH-1:0] mute_nxt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    amute_silence_det #(.SAMPLE_W(SAMPLE_W)) u_sil (
      .smp    (smp_i[c*SAMPLE_W +: SAMPLE_W]),
      .silent (silent[c])
    );
    amute_run_ctr #(.RUN_LEN(RUN_LEN)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .en       (en_i),
      .vld      (vld_i[c]),
      .silent   (silent[c]),
      .mute_q   (mute_o[c]),
      .mute_nxt (mute_nxt[c])
    );
  end

  amute_pin #(.NUM_CH(NUM_CH)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .mute_nxt (mute_nxt),
    .pin_q    (mute_pin_o)
  );
endmodule

// File: rtl/amute_detector_chk.sv
module amute_detector_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned NUM_CH   = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en_i,
  input logic [NUM_CH-1:0]          vld_i,
  input logic [NUM_CH*SAMPLE_W-1:0] smp_i,
  input logic [NUM_CH-1:0]          mute_o,
  input logic                       mute_pin_o
);
  a_r9_reset_clear: assert property (@(posedge clk) rst |=> (mute_o == '0 && !mute_pin_o));
  a_r7_pin_all: assert property (@(posedge clk) disable iff (rst) mute_pin_o == (&mute_o));
  a_r8_disable: assert property (@(posedge clk) disable iff (rst) !en_i |=> (mute_o == '0 && !mute_pin_o));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic sil;
    assign sil = (smp_i[c*SAMPLE_W +: SAMPLE_W] == {SAMPLE_W{1'b0}}) ||
                 (smp_i[c*SAMPLE_W +: SAMPLE_W] == {SAMPLE_W{1'b1}});
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
      (vld_i[c] && !sil) |=> !mute_o[c]);
    a_r2_rise_on_silent: assert property (@(posedge clk) disable iff (rst)
      $rose(mute_o[c]) |-> ($past(vld_i[c]) && $past(sil) && $past(en_i)));
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (mute_o[c] && en_i && vld_i[c] && sil) |=> mute_o[c]);
    a_r6_no_strobe: assert property (@(posedge clk) disable iff (rst)
      (en_i && !vld_i[c]) |=> $stable(mute_o[c]));
  end
endmodule

bind amute_detector amute_detector_chk #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .vld_i(vld_i), .smp_i(smp_i),
  .mute_o(mute_o), .mute_pin_o(mute_pin_o)
);

// File: tb/sim_amute_detector.sv
module sim_amute_detector;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic [1:0] vld = '0;
  logic [2*W-1:0] smp = '0;
  logic [1:0] mute;
  logic pin;

  int n_chk = 0;
  int n_fail = 0;
  int cnt_m [2];
  bit mut_m [2];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amute_detector #(.SAMPLE_W(W), .RUN_LEN(N), .NUM_CH(2)) u0 (
    .clk(clk), .rst(rst), .en_i(en), .vld_i(vld), .smp_i(smp),
    .mute_o(mute), .mute_pin_o(pin)
  );

  task automatic compare(input string tag);
    logic [1:0] em;
    em = {mut_m[1], mut_m[0]};
    n_chk++;
    if (mute !== em || pin !== (em == 2'b11)) begin
      n_fail++;
      $display("FAIL %s: mute=%b pin=%b expected mute=%b pin=%b",
               tag, mute, pin, em, (em == 2'b11));
    end
  endtask

  // One sample cycle: drive at falling edge, model, compare after rising edge.
  task automatic step(input logic [W-1:0] l, input logic [W-1:0] r,
                      input logic vl, input logic vr, input logic e, input string tag);
    logic [W-1:0] s [2];
    logic v [2];
    s[0] = l; s[1] = r; v[0] = vl; v[1] = vr;
    smp = {r, l}; vld = {vr, vl}; en = e;
    for (int c = 0; c < 2; c++) begin
      if (!e) begin
        cnt_m[c] = 0; mut_m[c] = 1'b0;
      end else if (v[c]) begin
        if (s[c] == '0 || s[c] == '1) begin
          if (cnt_m[c] < N) cnt_m[c]++;
          mut_m[c] = (cnt_m[c] == N);
        end else begin
          cnt_m[c] = 0; mut_m[c] = 1'b0;
        end
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cnt_m[0] = 0; cnt_m[1] = 0; mut_m[0] = 0; mut_m[1] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R9 reset state");

    // R2: zeros on left, no mute before sample N, mute on sample N
    for (int i = 1; i <= N; i++) step(8'h00, 8'h55, 1, 1, 1, "R2 left zero run");
    // R3: saturation keeps mute
    for (int i = 0; i < 3*N; i++) step(8'h00, 8'h55, 1, 1, 1, "R3 saturate hold");
    // R4: one non-silent sample releases, restart needs full run
    step(8'h01, 8'h55, 1, 1, 1, "R4 release");
    for (int i = 1; i <= N; i++) step((i % 2) ? 8'hFF : 8'h00, 8'h55, 1, 1, 1, "R1 R4 mixed 0/-1 rerun");
    // R5/R7: right channel alone then both muted
    for (int i = 1; i <= N; i++) step(8'h00, 8'hFF, 1, 1, 1, "R5 R7 right run");
    step(8'h80, 8'h00, 1, 1, 1, "R7 pin drops on left release");
    // R6: no strobe, noisy bus has no effect
    for (int i = 0; i < N + 4; i++) step(8'h7F, 8'h80, 0, 0, 1, "R6 strobe low");
    for (int i = 1; i < N; i++) step(8'h00, 8'h00, 1, 0, 1, "R6 left only strobe");
    step(8'h00, 8'h00, 1, 1, 1, "R2 R7 both muted");
    // R8: disable clears, and no mute while off
    step(8'h00, 8'h00, 1, 1, 0, "R8 disable clears");
    for (int i = 0; i < 2*N; i++) step(8'h00, 8'h00, 1, 1, 0, "R8 no mute while off");
    for (int i = 1; i <= N; i++) step(8'hFF, 8'hFF, 1, 1, 1, "R8 re-enable needs full run");
    // R1: sweep every value on both channels
    for (int v = 0; v < 256; v++) begin
      step(8'h55, 8'h2A, 1, 1, 1, "R4 sweep restart");
      for (int i = 1; i <= N; i++) step(8'(v), 8'(255 - v), 1, 1, 1, "R1 value sweep");
    end
    // R9: reset mid-mute
    for (int i = 1; i <= N; i++) step(8'h00, 8'h00, 1, 1, 1, "R9 pre-reset run");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cnt_m[0] = 0; cnt_m[1] = 0; mut_m[0] = 0; mut_m[1] = 0;
    compare("R9 reset clears mute");
    for (int i = 1; i < N; i++) step(8'h00, 8'h00, 1, 1, 1, "R9 count restarted");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule